// File: doc/BRIEF.md
# Host Serial Command Slave

This block is the chip-side end of a synchronous serial link to an external host controller. The host raises an active-high select, clocks in a mode byte, and then either pushes command bytes into the chip or pulls data bytes out of it. The mode byte carries a six-bit code and a direction bit. The slave compares the code with a value held inside the chip. It answers on its serial output: low means accepted and high means refused. After a refusal the rest of the transfer is ignored.

The serial clock, select and input data are brought into the system clock domain through two-flop synchronisers. All serial edges are found there by edge detection, so the system clock must run several times faster than the serial clock. Received command bytes go to internal logic as one-cycle strobes. For host reads, the block asks internal logic for the next byte one byte ahead of when it is needed. An active-low busy output tells the host when the chip cannot take a transfer. The serial output can run push-pull or three-state.

Top module: `cmdSerialSlave`

## Requirements
- R1: After reset, misoOut is 1, cmdValid and rdReq are 0, and busyN is 1 while coreBusy is 0.
- R2: Bits are sampled on rising serial clock edges, first bit most significant. The first six bits of the mode byte form the code. After the mode byte's eighth rising edge, misoOut is 0 (ACK) if the code equals matchCode and stays 1 (NACK) otherwise.
- R3: If the seventh mode bit is 0 and the code matched, each following group of eight bits produces one single-cycle cmdValid pulse with that byte, first bit most significant, on cmdByte.
- R4: If the seventh mode bit is 1 and the code matched, ACK holds until the next falling edge. From then on the slave shifts out bytes on misoOut, first bit most significant, changing on falling edges. Each byte is the one delivered on rdByte with rdValid in answer to its request.
- R5: In read direction, if no rdValid has arrived for a byte by the time that byte starts, the slave sends 0xFF.
- R6: After a NACK, misoOut stays 1 until select drops, and there is no cmdValid and no rdReq for that transfer.
- R7: The eighth bit of the mode byte has no effect on ACK, direction or data.
- R8: Dropping selIn at any point clears the bit count and the direction. The next transfer starts with a new mode byte.
- R9: When tristateMode is 1, misoOe is 0 while select is low and 1 while it is high. When tristateMode is 0, misoOe is always 1.
- R10: busyN is the inverse of coreBusy, delayed by one system clock.
- R11: A read transfer of N bytes raises exactly N+1 single-cycle rdReq pulses: one when the mode byte is accepted, and one as each byte starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclkIn | input | 1 | Serial clock from host, idle high |
| selIn | input | 1 | Active-high transfer select |
| mosiIn | input | 1 | Serial data from host |
| misoOut | output | 1 | Serial data / ACK to host |
| misoOe | output | 1 | Output enable for misoOut |
| tristateMode | input | 1 | 1 selects three-state output |
| matchCode | input | 6 | Code the mode byte must match |
| coreBusy | input | 1 | Internal logic not ready |
| busyN | output | 1 | Active-low busy to host |
| cmdValid | output | 1 | One-cycle strobe for a received command byte |
| cmdByte | output | 8 | Received command byte |
| rdReq | output | 1 | Request for the next read byte |
| rdValid | input | 1 | Read byte available |
| rdByte | input | 8 | Read byte from internal logic |

## Verification
The bench targets the bit alignment of the mode byte. A design that took the code from the wrong bit positions, or let the eighth bit affect the result, would ACK the wrong codes. A transfer aborted partway through a byte is followed by a good transfer. A counter that did not clear would then misframe every later byte and report commands that do not match. Read transfers are run both with the internal side answering and with it silent. These catch a wrong prefetch count, bytes sent one position late, and a missing 0xFF fill. Refused transfers are clocked for several bytes so that any leak of strobes or data shows up.

// File: rtl/hss_pkg.sv
package hss_pkg;
  typedef enum logic [1:0] {OUT_HIGH, OUT_ACK, OUT_DATA} outSel_t;

  typedef struct packed {
    logic    shiftIn;
    logic    emitCmd;
    logic    loadTx;
    logic    shiftTx;
    logic    holdEn;
    logic    clearHold;
    outSel_t outSel;
  } hssStrobe_t;
endpackage

// File: rtl/hssSync.sv
module hssSync #(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkIn,
  input  logic [LVL_W-1:0] lvlIn,
  output logic [LVL_W-1:0] lvlOut,
  output logic             sclkRise,
  output logic             sclkFall
);
  logic [1:0] clkPipe;
  logic       clkPrev;

  for (genvar i = 0; i < LVL_W; i++) begin : gLvl
    logic [1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[0], lvlIn[i]};
    end
    assign lvlOut[i] = pipe[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      clkPrev <= 1'b0;
    end else begin
      clkPipe <= {clkPipe[0], sclkIn};
      clkPrev <= clkPipe[1];
    end
  end

  assign sclkRise = clkPipe[1] & ~clkPrev;
  assign sclkFall = ~clkPipe[1] & clkPrev;
endmodule

// File: rtl/hssCtrl.sv
module hssCtrl
  import hss_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selSync,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic [CODE_W-1:0] modeCode,
  input  logic              modeDir,
  input  logic [CODE_W-1:0] matchCode,
  output hssStrobe_t        str,
  output logic              rdReq
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {PH_MODE, PH_WRITE, PH_RDACK, PH_READ, PH_REJECT} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             byteEnd, byteStart, readSide;

  assign byteEnd   = selSync && sclkRise && (bitCnt == BIT_LAST);
  assign byteStart = selSync && sclkFall && (bitCnt == '0);
  assign readSide  = (phase == PH_RDACK) || (phase == PH_READ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_MODE;
      bitCnt <= '0;
      rdReq  <= 1'b0;
    end else if (!selSync) begin
      phase  <= PH_MODE;
      bitCnt <= '0;
      rdReq  <= 1'b0;
    end else begin
      rdReq <= 1'b0;
      if (sclkRise) bitCnt <= bitCnt + 1'b1;
      if (byteEnd && phase == PH_MODE) begin
        if (modeCode != matchCode) phase <= PH_REJECT;
        else if (modeDir) begin
          phase <= PH_RDACK;
          rdReq <= 1'b1;
        end else phase <= PH_WRITE;
      end
      if (byteStart && readSide) begin
        phase <= PH_READ;
        rdReq <= 1'b1;
      end
    end
  end

  always_comb begin
    str           = '0;
    str.shiftIn   = selSync && sclkRise;
    str.emitCmd   = byteEnd && (phase == PH_WRITE);
    str.loadTx    = byteStart && readSide;
    str.shiftTx   = selSync && sclkFall && (bitCnt != '0) && (phase == PH_READ);
    str.holdEn    = selSync && readSide;
    str.clearHold = !selSync;
    case (phase)
      PH_WRITE, PH_RDACK: str.outSel = OUT_ACK;
      PH_READ:            str.outSel = OUT_DATA;
      default:            str.outSel = OUT_HIGH;
    endcase
  end

  assert_req_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    !selSync |=> (bitCnt == '0));
  assert_reject_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_REJECT) |=> (phase == PH_REJECT || phase == PH_MODE));
endmodule

// File: rtl/hssDatapath.sv
module hssDatapath
  import hss_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mosiSync,
  input  hssStrobe_t        str,
  input  logic              rdValid,
  input  logic [BYTE_W-1:0] rdByte,
  output logic [BYTE_W-1:0] rxFull,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdByte,
  output logic              misoOut
);
  logic [BYTE_W-1:0] rxShift, holdByte, txShift, txSrc;
  logic              holdFull, txBit;

  assign rxFull = {rxShift[BYTE_W-2:0], mosiSync};
  assign txSrc  = holdFull ? holdByte : (rdValid ? rdByte : '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      cmdValid <= 1'b0;
      cmdByte  <= '0;
      holdByte <= '0;
      holdFull <= 1'b0;
      txShift  <= '1;
      txBit    <= 1'b1;
    end else begin
      cmdValid <= str.emitCmd;
      if (str.shiftIn) rxShift <= rxFull;
      if (str.emitCmd) cmdByte <= rxFull;
      if (str.clearHold) holdFull <= 1'b0;
      else if (str.loadTx) begin
        txShift  <= txSrc;
        txBit    <= txSrc[BYTE_W-1];
        holdFull <= 1'b0;
      end else begin
        if (str.holdEn && rdValid && !holdFull) begin
          holdByte <= rdByte;
          holdFull <= 1'b1;
        end
        if (str.shiftTx) begin
          txShift <= {txShift[BYTE_W-2:0], 1'b1};
          txBit   <= txShift[BYTE_W-2];
        end
      end
    end
  end

  always_comb begin
    case (str.outSel)
      OUT_ACK:  misoOut = 1'b0;
      OUT_DATA: misoOut = txBit;
      default:  misoOut = 1'b1;
    endcase
  end

  assert_cmd_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
endmodule

// File: rtl/cmdSerialSlave.sv
module cmdSerialSlave
  import hss_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              selIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              tristateMode,
  input  logic [CODE_W-1:0] matchCode,
  input  logic              coreBusy,
  output logic              busyN,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdByte,
  output logic              rdReq,
  input  logic              rdValid,
  input  logic [BYTE_W-1:0] rdByte
);
  localparam int DIR_POS = BYTE_W - 1 - CODE_W;

  logic [1:0]        lvlSync;
  logic              selSync, mosiSync, sclkRise, sclkFall;
  logic [BYTE_W-1:0] rxFull;
  hssStrobe_t        str;

  hssSync #(.LVL_W(2)) uSync (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .lvlIn({selIn, mosiIn}),
    .lvlOut(lvlSync), .sclkRise(sclkRise), .sclkFall(sclkFall)
  );
  assign selSync  = lvlSync[1];
  assign mosiSync = lvlSync[0];

  hssCtrl #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .selSync(selSync), .sclkRise(sclkRise),
    .sclkFall(sclkFall), .modeCode(rxFull[BYTE_W-1 -: CODE_W]),
    .modeDir(rxFull[DIR_POS]), .matchCode(matchCode), .str(str), .rdReq(rdReq)
  );

  hssDatapath #(.BYTE_W(BYTE_W)) uData (
    .clk(clk), .rstN(rstN), .mosiSync(mosiSync), .str(str), .rdValid(rdValid),
    .rdByte(rdByte), .rxFull(rxFull), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .misoOut(misoOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyN <= 1'b1;
    else       busyN <= ~coreBusy;
  end

  assign misoOe = tristateMode ? selSync : 1'b1;

  assert_pushpull_R9: assert property (@(posedge clk) disable iff (!rstN)
    !tristateMode |-> misoOe);
  assert_cmd_read_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && rdReq));
endmodule

// File: tb/cmdSerialSlave_test.sv
module cmdSerialSlave_test;
  localparam int H = 10;
  localparam logic [5:0] CODE = 6'h2D;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclkIn = 1'b1, selIn = 1'b0, mosiIn = 1'b0, tristateMode = 1'b0;
  logic coreBusy = 1'b0, rdValid = 1'b0;
  logic [5:0] matchCode = CODE;
  logic [7:0] rdByte = 8'h00;
  logic misoOut, misoOe, busyN, cmdValid, rdReq;
  logic [7:0] cmdByte;

  int checks = 0, errors = 0;
  int cmdCount = 0, reqCount = 0, rdIdx = 0;
  bit respondEn = 1'b1;
  logic [7:0] cmdLog [256];
  logic [7:0] rdData [256];

  always #2 clk = ~clk;

  cmdSerialSlave uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .selIn(selIn), .mosiIn(mosiIn),
    .misoOut(misoOut), .misoOe(misoOe), .tristateMode(tristateMode),
    .matchCode(matchCode), .coreBusy(coreBusy), .busyN(busyN),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .rdReq(rdReq),
    .rdValid(rdValid), .rdByte(rdByte)
  );

  always @(negedge clk) begin
    rdValid = 1'b0;
    if (cmdValid) begin
      cmdLog[cmdCount[7:0]] = cmdByte;
      cmdCount++;
    end
    if (rdReq) begin
      reqCount++;
      if (respondEn) begin
        rdValid = 1'b1;
        rdByte  = rdData[rdIdx[7:0]];
        rdIdx++;
      end
    end
  end

  function automatic logic [7:0] modeByte(input logic [5:0] c, input logic dir, input logic junk);
    return {c, dir, junk};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xferBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      sclkIn = 1'b0; mosiIn = tx[i];
      tick(H);
      rx[i] = misoOut;
      sclkIn = 1'b1;
      tick(H);
    end
  endtask

  task automatic openXfer();
    selIn = 1'b1;
    tick(6);
  endtask

  task automatic closeXfer();
    selIn = 1'b0;
    tick(8);
  endtask

  // full transfer with expected-value checks
  task automatic runXfer(input logic [5:0] c, input logic dir, input logic junk,
                         input int nBytes, input string tag);
    logic [7:0] rx, tx;
    logic [7:0] sent [8];
    logic ok;
    int cmdBase, reqBase, idxBase;
    ok = (c == matchCode);
    cmdBase = cmdCount; reqBase = reqCount; idxBase = rdIdx;
    openXfer();
    xferBits(modeByte(c, dir, junk), 8, rx);
    tick(2);
    chk({tag, " R2 ack"}, {31'd0, misoOut}, {31'd0, !ok});
    for (int b = 0; b < nBytes; b++) begin
      tx = 8'($urandom);
      sent[b] = tx;
      xferBits(tx, 8, rx);
      if (!ok) chk({tag, " R6 nack data"}, {24'd0, rx}, 32'hFF);
      else if (dir) begin
        if (respondEn) chk({tag, " R4 read byte"}, {24'd0, rx}, {24'd0, rdData[8'(idxBase + b)]});
        else chk({tag, " R5 empty fill"}, {24'd0, rx}, 32'hFF);
      end
    end
    tick(4);
    closeXfer();
    if (ok && !dir) begin
      chk({tag, " R3 cmd count"}, cmdCount - cmdBase, nBytes);
      for (int b = 0; b < nBytes; b++)
        chk({tag, " R3 cmd byte"}, {24'd0, cmdLog[8'(cmdBase + b)]}, {24'd0, sent[b]});
    end else chk({tag, " R6 no cmd"}, cmdCount - cmdBase, 0);
    chk({tag, " R11 req count"}, reqCount - reqBase, (ok && dir) ? nBytes + 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    void'($urandom(32'd7151));
    for (int i = 0; i < 256; i++) rdData[i] = 8'($urandom);
    tick(5);
    rstN = 1'b1;
    tick(5);
    // R1 reset state
    chk("R1 miso", {31'd0, misoOut}, 1);
    chk("R1 cmdValid", {31'd0, cmdValid}, 0);
    chk("R1 rdReq", {31'd0, rdReq}, 0);
    chk("R1 busyN", {31'd0, busyN}, 1);
    // R10 busy
    coreBusy = 1'b1; tick(1);
    chk("R10 busy low", {31'd0, busyN}, 0);
    coreBusy = 1'b0; tick(1);
    chk("R10 busy high", {31'd0, busyN}, 1);
    // R9 output enable
    chk("R9 pushpull idle", {31'd0, misoOe}, 1);
    tristateMode = 1'b1; tick(1);
    chk("R9 tristate idle", {31'd0, misoOe}, 0);
    openXfer();
    chk("R9 tristate active", {31'd0, misoOe}, 1);
    closeXfer();
    chk("R9 tristate released", {31'd0, misoOe}, 0);
    tristateMode = 1'b0;
    // directed
    runXfer(CODE, 1'b0, 1'b0, 3, "write");
    runXfer(CODE, 1'b0, 1'b1, 2, "R7 junk bit write");
    runXfer(CODE, 1'b1, 1'b1, 4, "R7 read");
    respondEn = 1'b0;
    runXfer(CODE, 1'b1, 1'b0, 2, "R5 no data");
    respondEn = 1'b1;
    runXfer(CODE ^ 6'h01, 1'b0, 1'b0, 3, "R6 mismatch write");
    runXfer(CODE ^ 6'h20, 1'b1, 1'b0, 2, "R6 mismatch read");
    // R8 abort mid-byte then clean transfer
    openXfer();
    xferBits(8'hFF, 3, rx);
    closeXfer();
    runXfer(CODE, 1'b0, 1'b0, 2, "R8 after abort");
    openXfer();
    xferBits(modeByte(CODE, 1'b1, 1'b0), 8, rx);
    xferBits(8'h00, 5, rx);
    closeXfer();
    runXfer(CODE, 1'b0, 1'b1, 1, "R8 after read abort");
    // random
    for (int t = 0; t < 20; t++) begin
      logic [5:0] c;
      c = ($urandom % 2) ? CODE : 6'($urandom);
      respondEn = ($urandom % 4) != 0;
      runXfer(c, 1'($urandom), 1'($urandom), 1 + ($urandom % 4), "random");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule